// File: doc/BRIEF.md
# Parallel Quad-Serial Flash Bridge for a Read-Only Memory Window

This block sits behind a 16-bit memory window that the host can only read. The window has no read/write strobe and no bus clock of its own. The block connects that window to an array of serial flash devices run in quad mode, with each device supplying one nibble of every 16-bit word. The block also passes reads through to a larger parallel boot flash. A bank register picks which slice of that boot flash the window shows.

Because the host can only read, every command is encoded in the address of a read. A read in the control part of the register page latches the select level, the pin direction and a 4-bit value from low address bits. A read of the data port fires exactly one serial clock pulse, high for a fixed number of cycles, and returns the 16 bits sampled from the pins during that pulse. A read of the status port returns bit 0 of every device, so software can poll busy flags. A read of the bank port loads the bank register.

Host requests use valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and only one access is in flight at a time. The response stays on `rsp_valid`/`rsp_data` until the host raises `rsp_ready`. Until then, no new request is accepted, so the host can stall a response for any number of cycles.

Top module: `qspi_rom_bridge`

## Requirements
- R1: After reset: `flash_cs_n`=1, `flash_io_oe`=0, `flash_sclk`=0, `req_ready`=1, `rsp_valid`=0, and the bank register is 0.
- R2: A read whose word address has bits [16:8] not all ones is a boot flash read. For exactly one cycle `boot_rd`=1 and `boot_addr`={bank, word address}. The response returns the `boot_data` seen in that cycle.
- R3: A read of register-page offset with bits [7:6]=3 loads the bank register from address bits [1:0]. All later boot reads use the new bank.
- R4: A read of register-page offset with bits [7:6]=1 latches three fields: `flash_cs_n` from address bit 5, `flash_io_oe` from bit 4, and the nibble from bits [3:0]. The nibble is then driven on all four devices, so `flash_io_out` = {4{nibble}}. Nothing else changes these pins.
- R5: A read of register-page offset with bits [7:6]=0 produces exactly one `flash_sclk` pulse, high for PULSE_CYC cycles (default 2). No other access produces a pulse.
- R6: The data port returns `flash_io_in` as sampled in the last high cycle of its pulse. Device k occupies bits [4k+3:4k].
- R7: A read of register-page offset with bits [7:6]=2 returns `flash_io_in` bit 4k in result bit k for k=0..3. Bits [15:4] are zero.
- R8: `rsp_valid` and `rsp_data` hold steady until `rsp_ready`. `req_ready` stays low from acceptance until the response is taken.
- R9: Control and bank reads return 16'h0000.
- R10: While `flash_io_oe`=0 the bridge does not drive the pins, and data and status reads return the devices' values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | 17 | Word address inside the window |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | 16 | Read result |
| flash_cs_n | output | 1 | Shared device select, active low |
| flash_sclk | output | 1 | Shared serial clock |
| flash_io_oe | output | 1 | Bridge drives the IO pins when high |
| flash_io_out | output | 16 | Values driven on the IO pins |
| flash_io_in | input | 16 | Values sampled from the IO pins |
| boot_addr | output | 19 | Boot flash word address |
| boot_rd | output | 1 | Boot flash read strobe |
| boot_data | input | 16 | Boot flash read data |

## Verification
Two functions can fall in the same cycle: a stalled response and a new request that is already waiting. The bench loads the bank through a bank read and holds its response for several cycles. During that stall it keeps a boot read valid on the request side. It checks that `req_ready` stays low and the result stays stable while stalled. Once released, the waiting boot read must be accepted and must use the new bank. A reference model in the bench is compared on every clock for select, direction and driven nibble, and per access for results and pulse counts.

// File: rtl/qspib_pkg.sv
package qspib_pkg;
  typedef enum logic [1:0] {
    FN_DATA = 2'd0,
    FN_CTRL = 2'd1,
    FN_STAT = 2'd2,
    FN_BANK = 2'd3
  } fn_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BOOT,
    ST_HI,
    ST_RSP
  } st_e;

  typedef struct packed {
    logic is_reg;
    fn_e  fn;
  } dec_t;
endpackage

// File: rtl/qspib_decode.sv
module qspib_decode
  import qspib_pkg::*;
#(
  parameter int WADDR_W = 17,
  parameter int PAGE_W  = 8,
  localparam int TOP_W  = WADDR_W - PAGE_W + 2
) (
  input  logic [TOP_W-1:0] addr_hi,  // word address bits [WADDR_W-1 : PAGE_W-2]
  output dec_t             dec
);
  always_comb begin
    dec.is_reg = &addr_hi[TOP_W-1:2];
    dec.fn     = fn_e'(addr_hi[1:0]);
  end
endmodule

// File: rtl/qspib_pins.sv
module qspib_pins #(
  parameter int NDEV    = 4,
  localparam int NIB_W  = 4,
  localparam int DATA_W = NDEV * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [5:0]        ctrl,   // {cs_n, oe, nibble}
  output logic              cs_n,
  output logic              oe,
  output logic [DATA_W-1:0] io_out
);
  logic [NIB_W-1:0] nib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      oe    <= 1'b0;
      nib_q <= '0;
    end else if (load) begin
      cs_n  <= ctrl[5];
      oe    <= ctrl[4];
      nib_q <= ctrl[3:0];
    end
  end

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    assign io_out[k*NIB_W +: NIB_W] = nib_q;
  end

  // R4: pin state only moves on a control load
  a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cs_n) && $stable(oe) && $stable(io_out)));
endmodule

// File: rtl/qspib_pulse.sv
module qspib_pulse #(
  parameter int PULSE_CYC = 2,
  localparam int CNT_W    = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic sclk,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;
  int unsigned      hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      sclk  <= 1'b1;
      cnt_q <= CNT_W'(PULSE_CYC - 1);
    end else if (sclk) begin
      if (cnt_q == '0) sclk <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = sclk && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run <= 0;
    else if (sclk) hi_run <= hi_run + 1;
    else           hi_run <= 0;
  end

  // R5: every pulse is high for exactly PULSE_CYC cycles
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == PULSE_CYC));
endmodule

// File: rtl/qspi_rom_bridge.sv
module qspi_rom_bridge
  import qspib_pkg::*;
#(
  parameter int WADDR_W   = 17,
  parameter int BANK_W    = 2,
  parameter int PAGE_W    = 8,
  parameter int NDEV      = 4,
  parameter int PULSE_CYC = 2,
  localparam int DATA_W   = NDEV * 4,
  localparam int BOOT_AW  = WADDR_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WADDR_W-1:0] req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               flash_cs_n,
  output logic               flash_sclk,
  output logic               flash_io_oe,
  output logic [DATA_W-1:0]  flash_io_out,
  input  logic [DATA_W-1:0]  flash_io_in,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic               boot_rd,
  input  logic [DATA_W-1:0]  boot_data
);
  st_e               st_q;
  dec_t              dec;
  logic [BANK_W-1:0] bank_q;
  logic [BOOT_AW-1:0] baddr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [NDEV-1:0]   io0;
  logic              accept, pulse_last;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  qspib_decode #(.WADDR_W(WADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .addr_hi (req_addr[WADDR_W-1:PAGE_W-2]),
    .dec     (dec)
  );

  qspib_pins #(.NDEV(NDEV)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && dec.is_reg && dec.fn == FN_CTRL),
    .ctrl   (req_addr[5:0]),
    .cs_n   (flash_cs_n),
    .oe     (flash_io_oe),
    .io_out (flash_io_out)
  );

  qspib_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept && dec.is_reg && dec.fn == FN_DATA),
    .sclk  (flash_sclk),
    .last  (pulse_last)
  );

  for (genvar k = 0; k < NDEV; k++) begin : g_io0
    assign io0[k] = flash_io_in[4*k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bank_q  <= '0;
      baddr_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          if (!dec.is_reg) begin
            baddr_q <= {bank_q, req_addr};
            st_q    <= ST_BOOT;
          end else begin
            case (dec.fn)
              FN_DATA: st_q <= ST_HI;
              FN_CTRL: begin rdata_q <= '0; st_q <= ST_RSP; end
              FN_STAT: begin
                rdata_q <= {{(DATA_W-NDEV){1'b0}}, io0};
                st_q    <= ST_RSP;
              end
              default: begin
                bank_q  <= req_addr[BANK_W-1:0];
                rdata_q <= '0;
                st_q    <= ST_RSP;
              end
            endcase
          end
        end
        ST_BOOT: begin rdata_q <= boot_data; st_q <= ST_RSP; end
        ST_HI: if (pulse_last) begin rdata_q <= flash_io_in; st_q <= ST_RSP; end
        default: if (rsp_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == ST_RSP);
  assign rsp_data  = rdata_q;
  assign boot_rd   = (st_q == ST_BOOT);
  assign boot_addr = baddr_q;

  // R8: a held response is stable, and no request overlaps it
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r8_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  // R5: a pulse only starts on an accepted request
  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_sclk) |-> $past(accept));
  // R2: boot strobe lasts one cycle and leads to the response
  a_r2_boot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rd |=> (!boot_rd && rsp_valid));
  // R3: bank only moves on an accepted request
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(bank_q));
endmodule

// File: tb/qspi_rom_bridge_bench.sv
`timescale 1ns/1ps
module qspi_rom_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic [16:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic        flash_cs_n, flash_sclk, flash_io_oe;
  logic [15:0] flash_io_out, flash_io_in, boot_data;
  logic [18:0] boot_addr;
  logic        boot_rd;

  int errors = 0, checks = 0;
  bit done = 0;
  int resp_cnt = 0;
  int pulses = 0, hi_cyc = 0;
  bit prev_sclk = 0, run_chk = 0;
  bit m_cs = 1, m_oe = 0;
  logic [3:0] m_nib = '0;
  logic [1:0] m_bank = '0;

  always #2.5 clk = ~clk;

  qspi_rom_bridge u_qspi_rom_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk),
    .flash_io_oe(flash_io_oe), .flash_io_out(flash_io_out),
    .flash_io_in(flash_io_in), .boot_addr(boot_addr), .boot_rd(boot_rd),
    .boot_data(boot_data)
  );

  function automatic logic [15:0] dev_word(int c);
    int v;
    v = c * 32'h2D1B ^ 32'h9E37;
    return v[15:0];
  endfunction

  function automatic logic [15:0] boot_word(logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h00A5};
  endfunction

  // simple nibble-serial responder: advances on each falling clock in input mode
  always @(negedge flash_sclk) if (!flash_cs_n && !flash_io_oe) #1 resp_cnt++;
  assign flash_io_in = flash_io_oe ? flash_io_out : dev_word(resp_cnt);
  assign boot_data   = boot_word(boot_addr);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model's pin state
  always @(negedge clk) begin
    if (flash_sclk) hi_cyc++;
    if (flash_sclk && !prev_sclk) pulses++;
    prev_sclk = flash_sclk;
    if (run_chk) begin
      check(flash_cs_n == m_cs, "R4 cs_n", flash_cs_n, m_cs);
      check(flash_io_oe == m_oe, "R10 io_oe", flash_io_oe, m_oe);
      if (m_oe) check(flash_io_out == {4{m_nib}}, "R4 io_out", flash_io_out, {4{m_nib}});
    end
  end

  task automatic model_accept(logic [16:0] a);
    if (a[16:8] == 9'h1FF) begin
      if (a[7:6] == 2'd1) begin m_cs = a[5]; m_oe = a[4]; m_nib = a[3:0]; end
      if (a[7:6] == 2'd3) m_bank = a[1:0];
    end
  endtask

  function automatic logic [15:0] expect_for(logic [16:0] a);
    logic [15:0] w;
    if (a[16:8] != 9'h1FF) return boot_word({m_bank, a});
    w = m_oe ? {4{m_nib}} : dev_word(resp_cnt);
    case (a[7:6])
      2'd0: return w;
      2'd2: return {12'h000, w[12], w[8], w[4], w[0]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic access(logic [16:0] a, int stall, string tag);
    logic [15:0] exp, held;
    int exp_p;
    bit is_data;
    is_data = (a[16:8] == 9'h1FF) && (a[7:6] == 2'd0);
    exp_p = is_data ? 1 : 0;
    exp = expect_for(a);
    @(negedge clk);
    pulses = 0; hi_cyc = 0;
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #0.5;
    req_valid = 1'b0;
    model_accept(a);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == held && !req_ready, "R8 stall hold", rsp_data, held);
    end
    check(rsp_data == exp, tag, rsp_data, exp);
    check(pulses == exp_p, "R5 pulse count", pulses, exp_p);
    if (is_data) check(hi_cyc == 2, "R5 pulse width", hi_cyc, 2);
    rsp_ready = 1'b1;
    @(posedge clk); #0.5;
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    check(flash_cs_n == 1 && flash_io_oe == 0 && flash_sclk == 0, "R1 reset pins",
          {flash_cs_n, flash_io_oe, flash_sclk}, 3'b100);
    check(req_ready == 1 && rsp_valid == 0, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    run_chk = 1;
    access(17'h00123, 0, "R1 R2 boot read bank 0");
    access(17'h1FEFF, 0, "R2 boot read below register page");
    access(17'h1FFC3, 2, "R3 R9 bank load returns zero");
    access(17'h00123, 0, "R3 boot read uses bank 3");
    access(17'h1FF5B, 0, "R4 R9 control load out mode nibble B");
    access(17'h1FF00, 0, "R5 data pulse in output mode");
    access(17'h1FF80, 0, "R7 status with nibble B");
    access(17'h1FF5A, 0, "R4 control nibble A");
    access(17'h1FF80, 0, "R7 status with nibble A");
    access(17'h1FF40, 0, "R10 control input mode");
    for (int i = 0; i < 3; i++) access(17'h1FF00, i, "R6 data read input mode");
    access(17'h1FF80, 1, "R7 R10 status input mode");
    access(17'h1FF60, 0, "R4 select released");
    access(17'h1FF00, 0, "R5 R6 data with select high");
    access(17'h1FF40, 0, "R4 select low again");
    // R8 R3: bank response stalled while a boot read waits on the request side
    @(negedge clk);
    req_addr = 17'h1FFC1; req_valid = 1'b1;
    @(posedge clk); #0.5;
    model_accept(17'h1FFC1);
    req_addr = 17'h00456;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!req_ready && rsp_valid && rsp_data == 16'h0, "R8 overlap stall", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #0.5;
    rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #0.5;
    req_valid = 1'b0;
    exp = boot_word({m_bank, 17'h00456});
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    check(rsp_data == exp, "R3 R8 waiting boot read uses new bank", rsp_data, exp);
    rsp_ready = 1'b1;
    @(posedge clk); #0.5;
    rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule